// File: doc/BRIEF.md
# Internal Data Space Router

This block sits between an 8051-style core's operand datapath and its internal data targets. Each access presents an 8-bit address, a flag saying whether it was formed directly or through a pointer register, read and write strobes, write data, and a flag marking a single-bit operation. The router decides which target answers. The targets are a 256-byte scratch RAM held inside the block, a paged special-function-register space that lives outside, or the block's own SFR page register. The router then returns read data in the same cycle.

The lower half of the address space is plain RAM under either addressing mode. The upper half is ambiguous. A pointer-based access lands in the upper 128 bytes of RAM, while a direct access goes out to the SFR space of the current page. The page register answers one fixed direct address on every page, so software can always switch pages. Bit operations address sixteen RAM bytes starting at 0x20 for bit addresses below 0x80. When the option is enabled, bit addresses at 0x80 and above select aligned SFR bytes. A bit write is done as a read-modify-write of the whole byte.

Top module: `idata_router`

## Requirements
- R1: After reset every RAM byte reads as zero and `sfr_page` is zero.
- R2: A byte access to 0x00–0x7F uses RAM under either addressing mode. When a strobe is present, `ram_cs` is 1 and `sfr_cs` is 0.
- R3: An indirect (`indirect`=1) byte access to 0x80–0xFF uses RAM at that full address and never raises `sfr_cs`.
- R4: A direct byte access to 0x80–0xFF, other than the page register address, goes to the SFR space. With a strobe present, `sfr_cs` is 1, `ram_cs` is 0 and `sfr_addr` equals address bits 6:0. A write raises `sfr_we` with `sfr_wdata` equal to `wdata`, and a read returns `sfr_rdata`. RAM is unchanged.
- R5: A direct byte access to 0x84 reaches the page register on every page. A write loads `wdata` into `sfr_page` at the next rising edge, a read returns it, and neither raises `sfr_cs`. No other access changes `sfr_page`.
- R6: Reads are combinational. A write takes effect at the rising edge, so a read in the same cycle as a write returns the old value.
- R7: A bit operation with bit address 0x00–0x7F selects RAM byte 0x20 + (address >> 3) and bit (address & 7). A bit read returns that bit in `rdata` bit 0, with all other bits zero. A bit write replaces only that bit with `wdata` bit 0.
- R8: A bit operation with bit address 0x80–0xFF selects SFR byte (address & 0xF8), presenting offset (address & 0x78) on `sfr_addr`. A bit read returns that bit of `sfr_rdata` in bit 0. A bit write drives `sfr_wdata` as `sfr_rdata` with only that bit replaced.
- R9: With `rd_en` low, `rdata` is zero. With both strobes low, neither chip select is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Byte address, or bit address when `bit_op` is set |
| indirect | input | 1 | 1 = pointer-based access, 0 = direct |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data; bit 0 is the bit value for bit writes |
| bit_op | input | 1 | Access is a single-bit operation |
| rdata | output | 8 | Combinational read data |
| ram_cs | output | 1 | Internal RAM selected |
| sfr_cs | output | 1 | External SFR space selected |
| sfr_we | output | 1 | SFR write strobe |
| sfr_addr | output | 7 | SFR offset within the page |
| sfr_wdata | output | 8 | SFR write data (merged byte for bit writes) |
| sfr_rdata | input | 8 | Read data returned by the SFR space |
| sfr_page | output | 8 | Current SFR page |

## Verification
The bench builds the router with its default parameters: an 8-bit data path, a 256-byte RAM, a full 8-bit page register at 0x84, and SFR bit addressing enabled. That choice reaches all four routing outcomes, including the upper-bit-space path whose read-modify-write merges external data. It also lets random page values reach the whole page range. An SFR stub returns data that depends on both page and offset, so a wrong page or a wrong offset shows up in the read data.

// File: rtl/idr_pkg.sv
package idr_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_RAM  = 2'd1,
      TGT_SFR  = 2'd2,
      TGT_PAGE = 2'd3
   } idr_tgt_e;

   function automatic logic strobe_hits(input idr_tgt_e t, input idr_tgt_e want,
                                        input logic rd, input logic wr);
      return (rd | wr) & (t == want);
   endfunction
endpackage

// File: rtl/idr_decode.sv
module idr_decode
   import idr_pkg::*;
#(
   parameter int          ADDR_W        = 8,
   parameter int          DATA_W        = 8,
   parameter logic [7:0]  PAGE_REG_ADDR = 8'h84,
   parameter logic [7:0]  BIT_BASE      = 8'h20,
   parameter bit          SFR_BITS_EN   = 1'b1
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       indirect,
   input  logic                       bit_op,
   output idr_tgt_e                   tgt,
   output logic [ADDR_W-1:0]          byte_addr,
   output logic [$clog2(DATA_W)-1:0]  bit_idx
);
   localparam int BIT_IDX_W = $clog2(DATA_W);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W)'((1 << BIT_IDX_W) - 1));
   localparam logic [ADDR_W-1:0] PAGE_A     = PAGE_REG_ADDR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] BIT_BASE_A = BIT_BASE[ADDR_W-1:0];

   idr_tgt_e          hi_bit_tgt;
   logic [ADDR_W-1:0] hi_bit_byte;

   generate
      if (SFR_BITS_EN) begin : g_sfr_bits
         assign hi_bit_tgt  = TGT_SFR;
         assign hi_bit_byte = addr & ALIGN_MASK;
      end else begin : g_no_sfr_bits
         assign hi_bit_tgt  = TGT_NONE;
         assign hi_bit_byte = addr;
      end
   endgenerate

   always_comb begin
      bit_idx = addr[BIT_IDX_W-1:0];
      if (bit_op) begin
         if (!addr[ADDR_W-1]) begin
            tgt       = TGT_RAM;
            byte_addr = BIT_BASE_A + (addr >> BIT_IDX_W);
         end else begin
            tgt       = hi_bit_tgt;
            byte_addr = hi_bit_byte;
         end
      end else begin
         byte_addr = addr;
         if (!addr[ADDR_W-1] || indirect) begin
            tgt = TGT_RAM;
         end else if (addr == PAGE_A) begin
            tgt = TGT_PAGE;
         end else begin
            tgt = TGT_SFR;
         end
      end
   end
endmodule

// File: rtl/idr_ram.sv
module idr_ram #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= '0;
         end
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/idr_page_reg.sv
module idr_page_reg #(
   parameter int              PAGE_W     = 8,
   parameter logic [PAGE_W-1:0] RESET_PAGE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PAGE_W-1:0] wdata,
   output logic [PAGE_W-1:0] page
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page <= RESET_PAGE;
      end else if (we) begin
         page <= wdata;
      end
   end
endmodule

// File: rtl/idata_router.sv
module idata_router
   import idr_pkg::*;
#(
   parameter int          ADDR_W        = 8,
   parameter int          DATA_W        = 8,
   parameter int          PAGE_W        = 8,
   parameter logic [7:0]  PAGE_REG_ADDR = 8'h84,
   parameter logic [7:0]  BIT_BASE      = 8'h20,
   parameter bit          SFR_BITS_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              indirect,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              bit_op,
   output logic [DATA_W-1:0] rdata,
   output logic              ram_cs,
   output logic              sfr_cs,
   output logic              sfr_we,
   output logic [ADDR_W-2:0] sfr_addr,
   output logic [DATA_W-1:0] sfr_wdata,
   input  logic [DATA_W-1:0] sfr_rdata,
   output logic [PAGE_W-1:0] sfr_page
);
   localparam int BIT_IDX_W = $clog2(DATA_W);

   generate
      if (ADDR_W != 8) begin : g_bad_addr
         $error("idata_router: ADDR_W must be 8");
      end
      if (PAGE_W > DATA_W || PAGE_W < 1) begin : g_bad_page
         $error("idata_router: PAGE_W must lie in 1..DATA_W");
      end
      if (DATA_W != (1 << BIT_IDX_W)) begin : g_bad_data
         $error("idata_router: DATA_W must be a power of two");
      end
   endgenerate

   idr_tgt_e              tgt;
   logic [ADDR_W-1:0]     byte_addr;
   logic [BIT_IDX_W-1:0]  bit_idx;
   logic [DATA_W-1:0]     ram_rdata;
   logic [DATA_W-1:0]     page_rdata;
   logic [DATA_W-1:0]     cur_byte;
   logic [DATA_W-1:0]     merged;
   logic [DATA_W-1:0]     store_data;
   logic                  ram_we;
   logic                  page_we;

   idr_decode #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .PAGE_REG_ADDR (PAGE_REG_ADDR),
      .BIT_BASE      (BIT_BASE),
      .SFR_BITS_EN   (SFR_BITS_EN)
   ) u_decode (
      .addr      (addr),
      .indirect  (indirect),
      .bit_op    (bit_op),
      .tgt       (tgt),
      .byte_addr (byte_addr),
      .bit_idx   (bit_idx)
   );

   idr_ram #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ram_we),
      .addr  (byte_addr),
      .wdata (store_data),
      .rdata (ram_rdata)
   );

   idr_page_reg #(
      .PAGE_W     (PAGE_W),
      .RESET_PAGE ('0)
   ) u_page (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (page_we),
      .wdata (wdata[PAGE_W-1:0]),
      .page  (sfr_page)
   );

   generate
      if (PAGE_W == DATA_W) begin : g_page_full
         assign page_rdata = sfr_page;
      end else begin : g_page_ext
         assign page_rdata = {{(DATA_W-PAGE_W){1'b0}}, sfr_page};
      end
   endgenerate

   always_comb begin
      unique case (tgt)
         TGT_RAM:  cur_byte = ram_rdata;
         TGT_SFR:  cur_byte = sfr_rdata;
         TGT_PAGE: cur_byte = page_rdata;
         default:  cur_byte = '0;
      endcase
   end

   always_comb begin
      merged          = cur_byte;
      merged[bit_idx] = wdata[0];
   end

   assign store_data = bit_op ? merged : wdata;
   assign ram_we     = wr_en & (tgt == TGT_RAM);
   assign page_we    = wr_en & (tgt == TGT_PAGE);

   assign ram_cs    = strobe_hits(tgt, TGT_RAM, rd_en, wr_en);
   assign sfr_cs    = strobe_hits(tgt, TGT_SFR, rd_en, wr_en);
   assign sfr_we    = wr_en & (tgt == TGT_SFR);
   assign sfr_addr  = byte_addr[ADDR_W-2:0];
   assign sfr_wdata = store_data;

   always_comb begin
      if (!rd_en) begin
         rdata = '0;
      end else if (bit_op) begin
         rdata = {{(DATA_W-1){1'b0}}, cur_byte[bit_idx]};
      end else begin
         rdata = cur_byte;
      end
   end
endmodule

// File: rtl/idr_checker.sv
module idr_checker #(
   parameter int         ADDR_W        = 8,
   parameter int         DATA_W        = 8,
   parameter int         PAGE_W        = 8,
   parameter logic [7:0] PAGE_REG_ADDR = 8'h84
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              indirect,
   input logic              rd_en,
   input logic              wr_en,
   input logic [DATA_W-1:0] wdata,
   input logic              bit_op,
   input logic [DATA_W-1:0] rdata,
   input logic              ram_cs,
   input logic              sfr_cs,
   input logic              sfr_we,
   input logic [ADDR_W-2:0] sfr_addr,
   input logic [PAGE_W-1:0] sfr_page
);
   logic page_wr;
   logic sfr_byte_acc;
   assign page_wr = wr_en && !bit_op && !indirect && (addr == PAGE_REG_ADDR[ADDR_W-1:0]);
   assign sfr_byte_acc = (rd_en || wr_en) && !bit_op && !indirect && addr[ADDR_W-1]
                         && (addr != PAGE_REG_ADDR[ADDR_W-1:0]);

   AST_LOW_TO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_op && !addr[ADDR_W-1] && (rd_en || wr_en)) |-> (ram_cs && !sfr_cs)); // R2
   AST_INDIRECT_NO_SFR: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_op && indirect) |-> !sfr_cs); // R3
   AST_DIRECT_HI_SFR: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_byte_acc |-> (sfr_cs && !ram_cs && sfr_addr == addr[ADDR_W-2:0] && sfr_we == wr_en)); // R4
   AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      page_wr |=> (sfr_page == $past(wdata[PAGE_W-1:0]))); // R5
   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !page_wr |=> $stable(sfr_page)); // R5
   AST_PAGE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (page_wr || (rd_en && !bit_op && !indirect && addr == PAGE_REG_ADDR[ADDR_W-1:0])) |-> !sfr_cs); // R5
   AST_BIT_LOW_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_op && !addr[ADDR_W-1] && (rd_en || wr_en)) |-> (ram_cs && !sfr_cs)); // R7
   AST_BIT_READ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      bit_op |-> (rdata[DATA_W-1:1] == '0)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !wr_en) |-> (!ram_cs && !sfr_cs && rdata == '0)); // R9
   AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ram_cs, sfr_cs}) <= 1); // R4
endmodule

bind idata_router idr_checker #(
   .ADDR_W        (ADDR_W),
   .DATA_W        (DATA_W),
   .PAGE_W        (PAGE_W),
   .PAGE_REG_ADDR (PAGE_REG_ADDR)
) u_idr_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .indirect (indirect),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .wdata    (wdata),
   .bit_op   (bit_op),
   .rdata    (rdata),
   .ram_cs   (ram_cs),
   .sfr_cs   (sfr_cs),
   .sfr_we   (sfr_we),
   .sfr_addr (sfr_addr),
   .sfr_page (sfr_page)
);

// File: tb/test_idata_router.sv
module test_idata_router;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0;
   logic       indirect = 1'b0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic       bit_op = 1'b0;
   logic [7:0] rdata;
   logic       ram_cs;
   logic       sfr_cs;
   logic       sfr_we;
   logic [6:0] sfr_addr;
   logic [7:0] sfr_wdata;
   logic [7:0] sfr_rdata;
   logic [7:0] sfr_page;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0] mdl_ram [256];
   logic [7:0] mdl_page;

   always #2 clk = ~clk;

   function automatic logic [7:0] stub(input logic [7:0] pg, input logic [6:0] off);
      return {off, 1'b1} ^ pg ^ 8'h5A;
   endfunction

   assign sfr_rdata = stub(sfr_page, sfr_addr);

   idata_router i_idata_router (
      .clk(clk), .rst_n(rst_n), .addr(addr), .indirect(indirect),
      .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .bit_op(bit_op),
      .rdata(rdata), .ram_cs(ram_cs), .sfr_cs(sfr_cs), .sfr_we(sfr_we),
      .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
      .sfr_page(sfr_page)
   );

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   // target codes inside the bench: 1 RAM, 2 SFR, 3 page
   task automatic do_op(input logic [7:0] a, input logic ind, input logic r,
                        input logic w, input logic b, input logic [7:0] d);
      int         tg;
      logic [7:0] bya;
      logic [7:0] cur;
      logic [7:0] nv;
      logic [7:0] exp_rd;
      string      tag;
      @(negedge clk);
      addr = a; indirect = ind; rd_en = r; wr_en = w; bit_op = b; wdata = d;
      #1;
      if (b) begin
         tg  = a[7] ? 2 : 1;
         bya = a[7] ? {a[7:3], 3'b000} : 8'h20 + {3'b000, a[7:3]};
         tag = a[7] ? "R8" : "R7";
      end else begin
         bya = a;
         if (!a[7]) begin tg = 1; tag = "R2"; end
         else if (ind) begin tg = 1; tag = "R3"; end
         else if (a == 8'h84) begin tg = 3; tag = "R5"; end
         else begin tg = 2; tag = "R4"; end
      end
      cur = (tg == 1) ? mdl_ram[bya] : (tg == 2) ? stub(mdl_page, bya[6:0]) : mdl_page;
      nv = cur;
      if (b) nv[a[2:0]] = d[0]; else nv = d;
      exp_rd = !r ? 8'h00 : b ? {7'b0, cur[a[2:0]]} : cur;
      chk(!r ? "R9" : (w ? "R6" : tag), "rdata", rdata, exp_rd);
      chk((r | w) ? tag : "R9", "ram_cs", {7'b0, ram_cs}, {7'b0, (r | w) && tg == 1});
      chk((r | w) ? tag : "R9", "sfr_cs", {7'b0, sfr_cs}, {7'b0, (r | w) && tg == 2});
      if (tg == 2 && (r | w)) chk(tag, "sfr_addr", {1'b0, sfr_addr}, {1'b0, bya[6:0]});
      if (tg == 2 && w) chk(tag, "sfr_wdata", sfr_wdata, nv);
      @(posedge clk);
      if (w && tg == 1) mdl_ram[bya] = nv;
      if (w && tg == 3) mdl_page = d;
      #1;
      chk("R5", "sfr_page", sfr_page, mdl_page);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1DA7A));
      for (int i = 0; i < 256; i++) mdl_ram[i] = 8'h00;
      mdl_page = 8'h00;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "sfr_page after reset", sfr_page, 8'h00);
      rst_n = 1'b1;
      // R1: reset contents
      do_op(8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      do_op(8'h7F, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      do_op(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      // R3 then R4: same upper address, two modes
      do_op(8'h90, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C);
      do_op(8'h90, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC3);
      do_op(8'h90, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      do_op(8'h90, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      // R5: page switching, page register readable on every page
      do_op(8'h84, 1'b0, 1'b0, 1'b1, 1'b0, 8'h07);
      do_op(8'h84, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      do_op(8'hA8, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      do_op(8'h84, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF);
      do_op(8'h84, 1'b1, 1'b0, 1'b1, 1'b0, 8'h11);
      // R6: read during write returns old value
      do_op(8'h10, 1'b0, 1'b1, 1'b1, 1'b0, 8'hAA);
      do_op(8'h10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h55);
      // R7: bit region ends
      do_op(8'h0B, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01);
      do_op(8'h21, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      do_op(8'h7F, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF);
      do_op(8'h2F, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      do_op(8'h7F, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
      // R8: SFR bit write and read
      do_op(8'hE5, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      do_op(8'hE6, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
      // R9: idle
      do_op(8'hC0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77);
      // random mix
      for (int i = 0; i < 1500; i++) begin
         logic [7:0] ra;
         logic [3:0] sel;
         sel = 4'($urandom);
         ra  = 8'($urandom);
         if (sel == 4'd0) ra = 8'h84;
         do_op(ra, 1'($urandom), 1'($urandom), 1'($urandom),
               (sel >= 4'd12), 8'($urandom));
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule